// File: doc/BRIEF.md
# USB PHY Power-Up Reset Sequencer

This block walks a combined USB2/USB3 PHY and the USB controller behind it from a fully reset, powered-down condition to an operating one, one control line at a time and in a fixed order. It drives the active-low resets for the auxiliary-power domain, the controller, the USB3 PHY and the USB2 PHY power-on reset. It also drives the USB2 IDDQ (deep power-down) control, the USB3 test power-down control, the analog power enable and the PCS and PMA power-stable flags. The remaining outputs are the PLL spread-spectrum enable and forced VBUS-valid value/select pairs for both paths. Between the PHY release, the controller release and the VBUS override it inserts settle waits, each with its own length set by a parameter as a count of system clocks.

A one-cycle `start` pulse begins the power-up sequence from idle, or from the parked state that follows a stop. The reference-clock mode input is captured on that same cycle and held for the rest of the session. `ready` reports the finished sequence. A `stop` while running reasserts only the two PHY resets and parks the block. A `stop` during power-up abandons the sequence and returns every output to its idle value.

Top module: `usb_phy_pwrseq`

## Requirements
- R1: During and after reset every reset output is 0, IDDQ and test power-down are 1, and all power, spread-spectrum, VBUS and ready outputs are 0.
- R2: After an accepted start the block spends one cycle holding all resets, then clears IDDQ, then one cycle later clears test power-down, then one cycle later releases the USB3 PHY reset and the USB2 power-on reset together. The controller and auxiliary resets stay at 0.
- R3: After the PHY resets are released, analog power enable, PCS stable and PMA stable all rise together exactly WAIT_PHY_CYC+1 cycles later.
- R4: Spread-spectrum enable rises one cycle after the power-stable flags, and the controller and auxiliary resets rise together one cycle after that.
- R5: All four forced VBUS outputs (USB3 value and select, USB2 value and select) rise together exactly WAIT_CTRL_CYC+1 cycles after the controller reset is released.
- R6: `ready` rises exactly WAIT_VBUS_CYC+1 cycles after the VBUS overrides and is 1 only in the running state.
- R7: A stop while running drops `ready` in the same cycle. On the next cycle the two PHY resets return to 0, while the controller resets, power flags, spread spectrum and VBUS overrides keep their values.
- R8: A stop at any point of power-up returns all outputs to the R1 values on the next cycle, and the sequence does not resume on its own.
- R9: A start while power-up is in progress is ignored and does not change the timing. A start from the parked state restarts from the R1 output values.
- R10: `refclk_pad_sel_o` takes the value of `refclk_mode_i` at the accepted start and ignores later changes of the input.
- R11: When start and stop are both high in idle, stop wins and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin power-up (pulse) |
| stop_i | input | 1 | Power down or abort |
| refclk_mode_i | input | 1 | Reference clock from pad (1) or internal source (0) |
| refclk_pad_sel_o | output | 1 | Reference clock mode captured at start |
| aux_rst_n_o | output | 1 | Auxiliary-power domain reset, active low |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| u3phy_rst_n_o | output | 1 | USB3 PHY reset, active low |
| u2phy_por_n_o | output | 1 | USB2 PHY power-on reset, active low |
| u2_iddq_o | output | 1 | USB2 PHY IDDQ power-down, 1 = powered down |
| u3_testpd_o | output | 1 | USB3 PHY test power-down, 1 = powered down |
| ana_pwr_en_o | output | 1 | PHY analog power enable |
| pcs_stable_o | output | 1 | PCS power stable flag |
| pma_stable_o | output | 1 | PMA power stable flag |
| ssc_en_o | output | 1 | PLL spread-spectrum enable |
| u3_vbus_val_o | output | 1 | Forced USB3 VBUS-valid value |
| u3_vbus_sel_o | output | 1 | USB3 VBUS-valid override select |
| u2_vbus_val_o | output | 1 | Forced USB2 VBUS-valid value |
| u2_vbus_sel_o | output | 1 | USB2 VBUS-valid override select |
| ready_o | output | 1 | Sequence complete and running |

## Verification
All control outputs are decoded from the sequence state. A wrong state therefore shows on the port vector in the very next cycle, as a line raised out of order, too early, or held back. A miscounted settle wait shows as the power flags, the VBUS overrides or `ready` moving by one or more cycles. The bench catches this by sampling on both sides of each expected transition. A fault in the stop or abort paths shows one cycle after `stop`, as PHY resets that stay released or controller resets that drop when they should hold.

// File: rtl/usb_pwrseq_pkg.sv
package usb_pwrseq_pkg;

  // Encoding order matters: output decode uses ranges over it.
  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_HOLD   = 4'd1,
    S_IDDQ   = 4'd2,
    S_TPD    = 4'd3,
    S_PHYREL = 4'd4,
    S_W1     = 4'd5,
    S_STABLE = 4'd6,
    S_SSC    = 4'd7,
    S_CREL   = 4'd8,
    S_W2     = 4'd9,
    S_VBUS   = 4'd10,
    S_W3     = 4'd11,
    S_RUN    = 4'd12,
    S_PARK   = 4'd13
  } seq_state_e;

  typedef struct packed {
    logic aux_rst_n;
    logic ctrl_rst_n;
    logic u3phy_rst_n;
    logic u2phy_por_n;
    logic u2_iddq;
    logic u3_testpd;
    logic ana_pwr_en;
    logic pcs_stable;
    logic pma_stable;
    logic ssc_en;
    logic u3_vbus_val;
    logic u3_vbus_sel;
    logic u2_vbus_val;
    logic u2_vbus_sel;
  } phy_ctrl_t;

  function automatic logic is_wait(seq_state_e s);
    return (s == S_W1) || (s == S_W2) || (s == S_W3);
  endfunction

  function automatic logic is_powering(seq_state_e s);
    return (s != S_IDLE) && (s != S_RUN) && (s != S_PARK);
  endfunction

endpackage

// File: rtl/pwrseq_wait_timer.sv
module pwrseq_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) cnt_d = load_val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R3: an expired counter stays at zero until reloaded
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o);

  // R3: a nonzero load is not reported as done in the following cycle
  a_r3_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (load_val_i != '0)) |=> !done_o);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import usb_pwrseq_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int WAIT_PHY_CYC  = 20000,
  parameter int WAIT_CTRL_CYC = 20000,
  parameter int WAIT_VBUS_CYC = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tmr_done_i,
  output seq_state_e       state_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             mode_capture_o
);
  localparam logic [CNT_W-1:0] LOAD_PHY  = CNT_W'(WAIT_PHY_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_CTRL = CNT_W'(WAIT_CTRL_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_VBUS = CNT_W'(WAIT_VBUS_CYC - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_PARK: if (start_i) state_d = S_HOLD;
      S_HOLD:   state_d = S_IDDQ;
      S_IDDQ:   state_d = S_TPD;
      S_TPD:    state_d = S_PHYREL;
      S_PHYREL: state_d = S_W1;
      S_W1:     if (tmr_done_i) state_d = S_STABLE;
      S_STABLE: state_d = S_SSC;
      S_SSC:    state_d = S_CREL;
      S_CREL:   state_d = S_W2;
      S_W2:     if (tmr_done_i) state_d = S_VBUS;
      S_VBUS:   state_d = S_W3;
      S_W3:     if (tmr_done_i) state_d = S_RUN;
      S_RUN:    state_d = S_RUN;
      default:  state_d = S_IDLE;
    endcase
    // stop overrides everything (R7, R8, R11)
    if (stop_i) begin
      if (state_q == S_RUN)       state_d = S_PARK;
      else if (state_q == S_PARK) state_d = S_PARK;
      else                        state_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    tmr_load_o = is_wait(state_d) && (state_d != state_q);
    unique case (state_d)
      S_W1:    tmr_val_o = LOAD_PHY;
      S_W2:    tmr_val_o = LOAD_CTRL;
      S_W3:    tmr_val_o = LOAD_VBUS;
      default: tmr_val_o = '0;
    endcase
  end

  assign mode_capture_o = ((state_q == S_IDLE) || (state_q == S_PARK)) &&
                          (state_d == S_HOLD);
  assign state_o = state_q;

  // R8: stop during power-up always lands in idle
  a_r8_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && is_powering(state_q)) |=> (state_q == S_IDLE));

  // R7: stop while running parks the block
  a_r7_run_to_park: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && state_q == S_RUN) |=> (state_q == S_PARK));

  // R9: no restart while the sequence is in progress
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && is_powering(state_q)) |=> (state_q != S_HOLD));

  // R3: a wait state is not left before the timer reports expiry
  a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wait(state_q) && !tmr_done_i && !stop_i) |=> (state_q == $past(state_q)));

  // R11: stop wins over start in idle
  a_r11_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && stop_i) |=> (state_q == S_IDLE));

endmodule

// File: rtl/pwrseq_outdec.sv
module pwrseq_outdec
  import usb_pwrseq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       stop_i,
  output phy_ctrl_t  ctl_o,
  output logic       ready_o
);
  logic parked, phy_on, ctrl_on, pwr_ok, ssc_on, vbus_on;

  always_comb begin
    parked  = (state_i == S_PARK);
    phy_on  = state_i inside {[S_PHYREL:S_RUN]};
    ctrl_on = (state_i inside {[S_CREL:S_RUN]}) || parked;
    pwr_ok  = (state_i inside {[S_STABLE:S_RUN]}) || parked;
    ssc_on  = (state_i inside {[S_SSC:S_RUN]}) || parked;
    vbus_on = (state_i inside {[S_VBUS:S_RUN]}) || parked;

    ctl_o.aux_rst_n   = ctrl_on;
    ctl_o.ctrl_rst_n  = ctrl_on;
    ctl_o.u3phy_rst_n = phy_on;
    ctl_o.u2phy_por_n = phy_on;
    ctl_o.u2_iddq     = state_i inside {S_IDLE, S_HOLD};
    ctl_o.u3_testpd   = state_i inside {S_IDLE, S_HOLD, S_IDDQ};
    ctl_o.ana_pwr_en  = pwr_ok;
    ctl_o.pcs_stable  = pwr_ok;
    ctl_o.pma_stable  = pwr_ok;
    ctl_o.ssc_en      = ssc_on;
    ctl_o.u3_vbus_val = vbus_on;
    ctl_o.u3_vbus_sel = vbus_on;
    ctl_o.u2_vbus_val = vbus_on;
    ctl_o.u2_vbus_sel = vbus_on;
  end

  assign ready_o = (state_i == S_RUN) && !stop_i;

endmodule

// File: rtl/usb_phy_pwrseq.sv
module usb_phy_pwrseq
  import usb_pwrseq_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int WAIT_PHY_CYC  = 20000,
  parameter int WAIT_CTRL_CYC = 20000,
  parameter int WAIT_VBUS_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic refclk_mode_i,
  output logic refclk_pad_sel_o,
  output logic aux_rst_n_o,
  output logic ctrl_rst_n_o,
  output logic u3phy_rst_n_o,
  output logic u2phy_por_n_o,
  output logic u2_iddq_o,
  output logic u3_testpd_o,
  output logic ana_pwr_en_o,
  output logic pcs_stable_o,
  output logic pma_stable_o,
  output logic ssc_en_o,
  output logic u3_vbus_val_o,
  output logic u3_vbus_sel_o,
  output logic u2_vbus_val_o,
  output logic u2_vbus_sel_o,
  output logic ready_o
);
  seq_state_e       state;
  logic             tmr_load, tmr_done, mode_capture;
  logic [CNT_W-1:0] tmr_val;
  phy_ctrl_t        ctl;
  logic             mode_q;

  pwrseq_fsm #(
    .CNT_W(CNT_W), .WAIT_PHY_CYC(WAIT_PHY_CYC),
    .WAIT_CTRL_CYC(WAIT_CTRL_CYC), .WAIT_VBUS_CYC(WAIT_VBUS_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .tmr_done_i(tmr_done), .state_o(state), .tmr_load_o(tmr_load),
    .tmr_val_o(tmr_val), .mode_capture_o(mode_capture)
  );

  pwrseq_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .done_o(tmr_done)
  );

  pwrseq_outdec u_dec (
    .state_i(state), .stop_i(stop_i), .ctl_o(ctl), .ready_o(ready_o)
  );

  // reference clock mode, captured only on an accepted start (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mode_q <= 1'b0;
    else if (mode_capture) mode_q <= refclk_mode_i;
  end

  assign refclk_pad_sel_o = mode_q;
  assign aux_rst_n_o      = ctl.aux_rst_n;
  assign ctrl_rst_n_o     = ctl.ctrl_rst_n;
  assign u3phy_rst_n_o    = ctl.u3phy_rst_n;
  assign u2phy_por_n_o    = ctl.u2phy_por_n;
  assign u2_iddq_o        = ctl.u2_iddq;
  assign u3_testpd_o      = ctl.u3_testpd;
  assign ana_pwr_en_o     = ctl.ana_pwr_en;
  assign pcs_stable_o     = ctl.pcs_stable;
  assign pma_stable_o     = ctl.pma_stable;
  assign ssc_en_o         = ctl.ssc_en;
  assign u3_vbus_val_o    = ctl.u3_vbus_val;
  assign u3_vbus_sel_o    = ctl.u3_vbus_sel;
  assign u2_vbus_val_o    = ctl.u2_vbus_val;
  assign u2_vbus_sel_o    = ctl.u2_vbus_sel;

  // R4: controller leaves reset only with spread spectrum and power flags up
  a_r4_ssc_before_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n_o) |-> (ssc_en_o && pma_stable_o && u3phy_rst_n_o));

  // R6: ready only with every override and release in place
  a_r6_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (u3_vbus_val_o && u2_vbus_sel_o && aux_rst_n_o && !u2_iddq_o));

  // R10: captured mode holds while a session is in progress
  a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_capture) |=> $stable(refclk_pad_sel_o));

  // R2: the PHY is out of test power-down whenever its reset is released
  a_r2_phy_powered: assert property (@(posedge clk) disable iff (!rst_n)
    u3phy_rst_n_o |-> (!u3_testpd_o && !u2_iddq_o));

endmodule

// File: tb/usb_phy_pwrseq_bench.sv
`timescale 1ns/100ps
module usb_phy_pwrseq_bench;
  logic clk = 1'b0;
  logic rst_n, start_i, stop_i, refclk_mode_i;
  logic refclk_pad_sel_o, aux_rst_n_o, ctrl_rst_n_o, u3phy_rst_n_o, u2phy_por_n_o;
  logic u2_iddq_o, u3_testpd_o, ana_pwr_en_o, pcs_stable_o, pma_stable_o, ssc_en_o;
  logic u3_vbus_val_o, u3_vbus_sel_o, u2_vbus_val_o, u2_vbus_sel_o, ready_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_phy_pwrseq #(
    .CNT_W(16), .WAIT_PHY_CYC(3), .WAIT_CTRL_CYC(4), .WAIT_VBUS_CYC(5)
  ) u_usb_phy_pwrseq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .refclk_mode_i(refclk_mode_i), .refclk_pad_sel_o(refclk_pad_sel_o),
    .aux_rst_n_o(aux_rst_n_o), .ctrl_rst_n_o(ctrl_rst_n_o),
    .u3phy_rst_n_o(u3phy_rst_n_o), .u2phy_por_n_o(u2phy_por_n_o),
    .u2_iddq_o(u2_iddq_o), .u3_testpd_o(u3_testpd_o),
    .ana_pwr_en_o(ana_pwr_en_o), .pcs_stable_o(pcs_stable_o),
    .pma_stable_o(pma_stable_o), .ssc_en_o(ssc_en_o),
    .u3_vbus_val_o(u3_vbus_val_o), .u3_vbus_sel_o(u3_vbus_sel_o),
    .u2_vbus_val_o(u2_vbus_val_o), .u2_vbus_sel_o(u2_vbus_sel_o),
    .ready_o(ready_o)
  );

  // observed vector: {aux,ctrl,u3rst,u2por, iddq,tpd, ana,pcs,pma, ssc, u3v,u3s,u2v,u2s, ready}
  localparam logic [14:0] V_IDLE = 15'b0000_11_000_0_0000_0;
  localparam logic [14:0] V_W3   = 15'b1111_00_111_1_1111_0;
  localparam logic [14:0] V_RUN  = 15'b1111_00_111_1_1111_1;
  localparam logic [14:0] V_PARK = 15'b1100_00_111_1_1111_0;

  // {cycle offset after accepted start edge, expected vector}; waits 3/4/5
  localparam logic [20:0] SEQ_TBL [12] = '{
    {6'd0,  15'b0000_11_000_0_0000_0},
    {6'd1,  15'b0000_01_000_0_0000_0},
    {6'd2,  15'b0000_00_000_0_0000_0},
    {6'd3,  15'b0011_00_000_0_0000_0},
    {6'd6,  15'b0011_00_000_0_0000_0},
    {6'd7,  15'b0011_00_111_0_0000_0},
    {6'd8,  15'b0011_00_111_1_0000_0},
    {6'd9,  15'b1111_00_111_1_0000_0},
    {6'd13, 15'b1111_00_111_1_0000_0},
    {6'd14, 15'b1111_00_111_1_1111_0},
    {6'd19, 15'b1111_00_111_1_1111_0},
    {6'd20, 15'b1111_00_111_1_1111_1}
  };

  function automatic logic [14:0] obs();
    return {aux_rst_n_o, ctrl_rst_n_o, u3phy_rst_n_o, u2phy_por_n_o,
            u2_iddq_o, u3_testpd_o, ana_pwr_en_o, pcs_stable_o, pma_stable_o,
            ssc_en_o, u3_vbus_val_o, u3_vbus_sel_o, u2_vbus_val_o,
            u2_vbus_sel_o, ready_o};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // leaves the time just after the edge that accepts start
  task automatic pulse_start(input logic mode);
    @(negedge clk);
    start_i = 1'b1;
    refclk_mode_i = mode;
    @(posedge clk);
    #1 start_i = 1'b0;
    refclk_mode_i = ~mode;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    stop_i = 1'b1;
    @(posedge clk);
    #1 stop_i = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int cur;
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; refclk_mode_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'(obs()), 32'(V_IDLE));
    check("R1 mode in reset", 32'(refclk_pad_sel_o), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", 32'(obs()), 32'(V_IDLE));

    // R11: start and stop together in idle
    @(negedge clk);
    start_i = 1'b1; stop_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0; stop_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 stop beats start", 32'(obs()), 32'(V_IDLE));

    // table-driven full power-up, mode captured as 1
    pulse_start(1'b1);
    cur = 0;
    for (int i = 0; i < 12; i++) begin
      int d;
      string tag;
      d = int'(SEQ_TBL[i][20:15]);
      tag = (d < 3) ? "R2" : (d < 7) ? "R3" : (d < 10) ? "R4" : (d < 15) ? "R5" : "R6";
      repeat (d - cur) @(posedge clk);
      @(negedge clk);
      cur = d;
      check(tag, 32'(obs()), 32'(SEQ_TBL[i][14:0]));
    end
    check("R10 mode held at 1", 32'(refclk_pad_sel_o), 32'd1);

    // R7: stop while running
    @(negedge clk);
    stop_i = 1'b1;
    #1 check("R7 ready drops same cycle", 32'(ready_o), 32'd0);
    check("R7 controller still out of reset", 32'(ctrl_rst_n_o), 32'd1);
    @(posedge clk);
    #1 stop_i = 1'b0;
    @(negedge clk);
    check("R7 parked outputs", 32'(obs()), 32'(V_PARK));
    repeat (3) @(negedge clk);
    check("R7 park holds", 32'(obs()), 32'(V_PARK));

    // R9/R10: restart from park with mode 0, start again mid-sequence
    pulse_start(1'b0);
    @(negedge clk);
    check("R9 restart from full reset", 32'(obs()), 32'(V_IDLE));
    check("R10 mode recaptured 0", 32'(refclk_pad_sel_o), 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    start_i = 1'b1;
    refclk_mode_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    repeat (14) @(posedge clk);
    @(negedge clk);
    check("R9 ignored start, offset 19", 32'(obs()), 32'(V_W3));
    @(negedge clk);
    check("R9 ignored start, offset 20", 32'(obs()), 32'(V_RUN));
    check("R10 mode not recaptured", 32'(refclk_pad_sel_o), 32'd0);

    // R8: abort inside the first wait
    pulse_stop();
    pulse_start(1'b0);
    repeat (4) @(posedge clk);
    pulse_stop();
    @(negedge clk);
    check("R8 abort in PHY wait", 32'(obs()), 32'(V_IDLE));
    repeat (25) @(posedge clk);
    @(negedge clk);
    check("R8 no resume after abort", 32'(obs()), 32'(V_IDLE));

    // R8: abort inside the controller wait
    pulse_start(1'b0);
    repeat (10) @(posedge clk);
    pulse_stop();
    @(negedge clk);
    check("R8 abort in controller wait", 32'(obs()), 32'(V_IDLE));

    // R1/R11: stop alone in idle is harmless
    pulse_stop();
    @(negedge clk);
    check("R11 stop in idle", 32'(obs()), 32'(V_IDLE));

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule